// File: doc/BRIEF.md
# Soft-Input Hard-Output Viterbi Decoder for an 8-State Recursive Systematic Code

This block decodes one block of a rate-1/2 recursive systematic convolutional code. It is the front half of one constituent decoder in a turbo receiver. The code has eight trellis states. The recursion feeds back taps 2 and 3 of the delay line, and the parity output uses the recursion bit together with taps 1 and 3.

Each trellis step takes three signed log-likelihood values: the systematic channel value, the parity channel value and the a priori value that came from the other constituent. Before the branch metrics are formed, the a priori value is added to the systematic value. This lets a plain maximum-metric add-compare-select engine accept soft information without any other change. When the block serves as the lower constituent, the systematic input is held at zero.

The engine performs one add-compare-select step per clock and keeps every survivor decision for the whole block. After the last step it walks the trellis backwards from the best final state. It then emits the hard information bits in their original order, one per clock, together with a valid strobe.

Top module: `llr_viterbi_dec`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it rises, `out_valid` is 0. After reset the decoder accepts a fresh block that starts in state 0, even if the reset interrupted a block that was partly loaded or being emitted.
- R2: The encoder model is defined as follows. The recursion bit is w = u XOR d2 XOR d3. The parity bit is v = w XOR d1 XOR d3. The delay line then shifts, so that d3 takes d2, d2 takes d1 and d1 takes w. The encoder starts with all delay bits at 0. For any information sequence encoded this way, with error-free inputs, the decoder returns that sequence exactly, including the last bits of the unterminated block.
- R3: After every trellis step, the smallest of the eight path metrics is 0 and every path metric is below 2^(W_PM-1). Blocks whose inputs sit at full scale (+127 and -128) still decode correctly.
- R4: The a priori value is added to the systematic value before the branch metric is formed. The branch metric is u·(sys+apr) + v·par, and the surviving path is the one with the largest total. With the systematic input held at 0, parity and a priori values alone decode the block. A strong a priori value outvotes a weak, contrary systematic value.
- R5: All inputs are signed two's-complement log-likelihood ratios, and a positive value favours a 1. With parity and a priori inputs at zero, each decoded bit equals the sign of its nonzero systematic input: 1 when positive, 0 when negative.
- R6: Once the N_BLK-th input of a block is accepted, `out_valid` first reads high N_BLK+1 clock edges later. It then stays high for exactly N_BLK consecutive cycles, and the k-th valid cycle carries information bit k of the block.
- R7: While the decoder is tracing back or emitting, `in_valid` and the soft inputs are ignored. The path metrics, the block being emitted and the next block are unaffected by them.
- R8: On equal candidate metrics, the compare picks the predecessor whose oldest delay bit is 0. Traceback starts from the lowest-numbered state among those with the largest final metric. An all-zero input block therefore decodes to all zeros.
- R9: A single weak parity value of the wrong sign, in a block whose other inputs are strong and correct, is corrected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | One trellis step of soft input is present (taken only while loading) |
| in_sys | input | W_LLR | Systematic channel LLR, signed |
| in_par | input | W_LLR | Parity channel LLR, signed |
| in_apr | input | W_LLR | A priori LLR, signed |
| out_valid | output | 1 | Decoded bit strobe |
| out_bit | output | 1 | Hard information bit, in block order |

## Verification
The checker watches, on every cycle, that the path metrics stay normalised: one metric always sits at zero and none reaches the upper half of its range. It also checks that the metrics hold still while inputs must be ignored, that the trace phase begins right after the final input of a block, and that every run of valid outputs lasts exactly one block and comes only from the emit phase. Whether the decoded bits are correct can be shown only by the bench's scenarios. These scenarios cover error-free codewords, full-scale inputs, the zero-systematic lower-constituent case, a priori override, decoding from the systematic sign alone, tie resolution, a weak parity error, junk presented while busy, and a reset in the middle of a block. The bench's scenarios also establish the exact output latency.

// File: rtl/vitdec_pkg.sv
// Package: shared trellis definitions for the 8-state recursive systematic decoder.
// A state is the delay line {d3,d2,d1}, with bit 0 holding d1 (the newest recursion bit).
// Assumes the recursion w = u^d2^d3 and the parity v = w^d1^d3.
package vitdec_pkg;

    localparam int NUM_ST = 8;

    typedef enum logic [1:0] {
        PH_ACS   = 2'd0,
        PH_TRACE = 2'd1,
        PH_EMIT  = 2'd2
    } phase_t;

    // Predecessor of next-state ns, where b is the delay bit that falls out of the line.
    function automatic logic [2:0] pred_of(input logic [2:0] ns, input logic b);
        return {b, ns[2], ns[1]};
    endfunction

    // Information bit on the branch that enters ns from the predecessor chosen by b.
    function automatic logic info_bit(input logic [2:0] ns, input logic b);
        return ns[0] ^ ns[2] ^ b;
    endfunction

    // Parity bit on the branch that enters ns from the predecessor chosen by b.
    function automatic logic par_bit(input logic [2:0] ns, input logic b);
        return ns[0] ^ ns[1] ^ b;
    endfunction

endpackage

// File: rtl/vitdec_bmu.sv
// Branch metric unit: adds the a priori value to the systematic value, then forms
// the four branch metrics u*(sys+apr) + v*par, indexed by {u,v}.
// Assumes W_BM >= W_LLR+2, so that no sum can overflow.
module vitdec_bmu #(
    parameter int W_LLR = 8,
    parameter int W_BM  = W_LLR + 2
) (
    input  logic signed [W_LLR-1:0] sys,
    input  logic signed [W_LLR-1:0] par,
    input  logic signed [W_LLR-1:0] apr,
    output logic signed [W_BM-1:0]  bm [4]
);

    logic signed [W_BM-1:0] l_info;
    logic signed [W_BM-1:0] l_par;

    // Combined information-bit LLR, and the sign-extended parity LLR.
    assign l_info = W_BM'(sys) + W_BM'(apr);
    assign l_par  = W_BM'(par);

    for (genvar k = 0; k < 4; k++) begin : g_bm
        localparam bit U = (k / 2) == 1;
        localparam bit V = (k % 2) == 1;
        // Metric of the branch that carries information bit U and parity bit V.
        assign bm[k] = (U ? l_info : '0) + (V ? l_par : '0);
    end

endmodule

// File: rtl/vitdec_acs.sv
// Add-compare-select array: eight path metrics, one trellis step per enabled clock.
// Keeps the larger candidate, resolving ties toward the predecessor whose oldest bit is 0.
// Then subtracts the minimum new metric from every metric.
// Assumes the metric spread stays below 2^(W_PM-1); INIT_GAP sets the head start of state 0.
module vitdec_acs
    import vitdec_pkg::*;
#(
    parameter int W_PM     = 14,
    parameter int W_BM     = 10,
    parameter int INIT_GAP = 2048
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   step_en,
    input  logic                   restart,
    input  logic signed [W_BM-1:0] bm [4],
    output logic [W_PM-1:0]        pm [NUM_ST],
    output logic [NUM_ST-1:0]      dec,
    output logic [2:0]             best_st
);

    localparam int W_C = W_PM + 2;

    logic [W_PM-1:0]        pm_q [NUM_ST];
    logic [W_PM-1:0]        pm_n [NUM_ST];
    logic signed [W_C-1:0]  win  [NUM_ST];

    for (genvar s = 0; s < NUM_ST; s++) begin : g_acs
        localparam logic [2:0] P0 = pred_of(3'(s), 1'b0);
        localparam logic [2:0] P1 = pred_of(3'(s), 1'b1);
        localparam logic [1:0] K0 = {info_bit(3'(s), 1'b0), par_bit(3'(s), 1'b0)};
        localparam logic [1:0] K1 = {info_bit(3'(s), 1'b1), par_bit(3'(s), 1'b1)};
        logic signed [W_C-1:0] c0;
        logic signed [W_C-1:0] c1;
        // Candidate metrics from both predecessors.
        assign c0 = $signed({2'b00, pm_q[P0]}) + W_C'(bm[K0]);
        assign c1 = $signed({2'b00, pm_q[P1]}) + W_C'(bm[K1]);
        // Strict compare: a tie keeps the predecessor whose dropped bit is 0.
        assign dec[s] = c1 > c0;
        assign win[s] = (c1 > c0) ? c1 : c0;
    end

    // Normalise the survivors by subtracting the smallest of them.
    always_comb begin
        logic signed [W_C-1:0] mn;
        logic signed [W_C-1:0] df;
        mn = win[0];
        for (int i = 1; i < NUM_ST; i++) begin
            if (win[i] < mn) mn = win[i];
        end
        for (int i = 0; i < NUM_ST; i++) begin
            df      = win[i] - mn;
            pm_n[i] = df[W_PM-1:0];
        end
    end

    // Pick the state with the largest stored metric, lowest index on ties.
    always_comb begin
        logic [W_PM-1:0] bv;
        bv      = pm_q[0];
        best_st = 3'd0;
        for (int i = 1; i < NUM_ST; i++) begin
            if (pm_q[i] > bv) begin
                bv      = pm_q[i];
                best_st = 3'(i);
            end
        end
    end

    // Metric registers: start state 0 ahead, otherwise take one normalised step.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            for (int i = 0; i < NUM_ST; i++) begin
                pm_q[i] <= (i == 0) ? W_PM'(INIT_GAP) : '0;
            end
        end else if (step_en) begin
            for (int i = 0; i < NUM_ST; i++) begin
                pm_q[i] <= pm_n[i];
            end
        end
    end

    assign pm = pm_q;

endmodule

// File: rtl/vitdec_trace.sv
// Survivor store and traceback: holds all N_BLK decision vectors and walks them backwards.
// It writes the hard bits into a block buffer, then replays that buffer forward as outputs.
// Assumes the controller supplies one index for writing, tracing and emitting.
module vitdec_trace
    import vitdec_pkg::*;
#(
    parameter int N_BLK = 64,
    parameter int W_IDX = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [W_IDX-1:0]  idx,
    input  logic [NUM_ST-1:0] dec_in,
    input  logic              tr_en,
    input  logic              first,
    input  logic [2:0]        best_st,
    input  logic              emit_en,
    output logic              out_valid,
    output logic              out_bit
);

    logic [NUM_ST-1:0] surv [N_BLK];
    logic [N_BLK-1:0]  hard_q;
    logic [2:0]        st_q;
    logic [2:0]        cur_st;
    logic              d_bit;

    assign cur_st = first ? best_st : st_q;
    assign d_bit  = surv[idx][cur_st];

    // Store the decision vector of each accepted trellis step.
    always_ff @(posedge clk) begin
        if (wr_en) surv[idx] <= dec_in;
    end

    // Record the hard bit recovered at each traceback step.
    always_ff @(posedge clk) begin
        if (tr_en) hard_q[idx] <= info_bit(cur_st, d_bit);
    end

    // Traceback state and the registered output strobe and bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= 3'd0;
            out_valid <= 1'b0;
            out_bit   <= 1'b0;
        end else begin
            if (tr_en) st_q <= pred_of(cur_st, d_bit);
            out_valid <= emit_en;
            out_bit   <= emit_en ? hard_q[idx] : 1'b0;
        end
    end

endmodule

// File: rtl/llr_viterbi_dec.sv
// Top: soft-input, hard-output Viterbi decoder for one block of N_BLK steps.
// Phases: load (one ACS step per accepted input), trace (N_BLK cycles) and emit (N_BLK cycles).
// Assumes the block starts in state 0 and has no tail termination.
module llr_viterbi_dec #(
    parameter int N_BLK    = 64,
    parameter int W_LLR    = 8,
    parameter int W_PM     = 14,
    parameter int INIT_GAP = 2048
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [W_LLR-1:0] in_sys,
    input  logic signed [W_LLR-1:0] in_par,
    input  logic signed [W_LLR-1:0] in_apr,
    output logic                    out_valid,
    output logic                    out_bit
);

    import vitdec_pkg::*;

    localparam int W_BM  = W_LLR + 2;
    localparam int W_IDX = (N_BLK > 1) ? $clog2(N_BLK) : 1;
    localparam logic [W_IDX-1:0] IDX_LAST = W_IDX'(N_BLK - 1);

    phase_t             phase_q;
    logic [W_IDX-1:0]   idx_q;
    logic               first_q;
    logic signed [W_BM-1:0] bm [4];
    logic [W_PM-1:0]    pm [NUM_ST];
    logic [NUM_ST-1:0]  dec;
    logic [2:0]         best_st;
    logic               accept;
    logic               restart;
    logic [NUM_ST*W_PM-1:0] pm_flat;

    assign accept  = (phase_q == PH_ACS) && in_valid;
    assign restart = (phase_q == PH_EMIT) && (idx_q == IDX_LAST);

    for (genvar s = 0; s < NUM_ST; s++) begin : g_flat
        assign pm_flat[s*W_PM +: W_PM] = pm[s];
    end

    // Phase sequencing and the shared step index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_ACS;
            idx_q   <= '0;
            first_q <= 1'b0;
        end else begin
            case (phase_q)
                PH_ACS: begin
                    if (in_valid) begin
                        if (idx_q == IDX_LAST) begin
                            phase_q <= PH_TRACE;
                            first_q <= 1'b1;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                        end
                    end
                end
                PH_TRACE: begin
                    first_q <= 1'b0;
                    if (idx_q == '0) phase_q <= PH_EMIT;
                    else             idx_q   <= idx_q - 1'b1;
                end
                PH_EMIT: begin
                    if (idx_q == IDX_LAST) begin
                        phase_q <= PH_ACS;
                        idx_q   <= '0;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: begin
                    phase_q <= PH_ACS;
                    idx_q   <= '0;
                end
            endcase
        end
    end

    vitdec_bmu #(.W_LLR(W_LLR), .W_BM(W_BM)) u_bmu (
        .sys (in_sys),
        .par (in_par),
        .apr (in_apr),
        .bm  (bm)
    );

    vitdec_acs #(.W_PM(W_PM), .W_BM(W_BM), .INIT_GAP(INIT_GAP)) u_acs (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_en (accept),
        .restart (restart),
        .bm      (bm),
        .pm      (pm),
        .dec     (dec),
        .best_st (best_st)
    );

    vitdec_trace #(.N_BLK(N_BLK), .W_IDX(W_IDX)) u_trace (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (accept),
        .idx       (idx_q),
        .dec_in    (dec),
        .tr_en     (phase_q == PH_TRACE),
        .first     (first_q),
        .best_st   (best_st),
        .emit_en   (phase_q == PH_EMIT),
        .out_valid (out_valid),
        .out_bit   (out_bit)
    );

endmodule

// File: rtl/llr_viterbi_dec_chk.sv
// Checker: cycle-level properties of the decoder's metrics, phases and output strobe.
// Attached to every instance of the top module by the bind at the end of this file.
module llr_viterbi_dec_chk
    import vitdec_pkg::*;
#(
    parameter int N_BLK = 64,
    parameter int W_PM  = 14,
    parameter int W_IDX = 6
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input phase_t                 phase,
    input logic [W_IDX-1:0]       idx,
    input logic                   out_valid,
    input logic [NUM_ST*W_PM-1:0] pm_flat
);

    logic             any_zero;
    logic             all_low;
    logic [W_IDX+1:0] run_cnt;

    // Floor and ceiling flags over the eight metric slices.
    always_comb begin
        any_zero = 1'b0;
        all_low  = 1'b1;
        for (int i = 0; i < NUM_ST; i++) begin
            if (pm_flat[i*W_PM +: W_PM] == '0) any_zero = 1'b1;
            if (pm_flat[i*W_PM + W_PM - 1])    all_low  = 1'b0;
        end
    end

    // Length of the current run of valid outputs.
    always_ff @(posedge clk) begin
        if (!rst_n)         run_cnt <= '0;
        else if (out_valid) run_cnt <= run_cnt + 1'b1;
        else                run_cnt <= '0;
    end

    assert_metric_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
        any_zero);

    assert_metric_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        all_low);

    assert_hold_metrics_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_ACS && !(phase == PH_EMIT && idx == W_IDX'(N_BLK - 1)))
        |=> $stable(pm_flat));

    assert_trace_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ACS && in_valid && idx == W_IDX'(N_BLK - 1)) |=> (phase == PH_TRACE));

    assert_out_from_emit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($past(phase) == PH_EMIT));

    assert_run_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_valid) |-> (run_cnt == (W_IDX+2)'(N_BLK)));

endmodule

bind llr_viterbi_dec llr_viterbi_dec_chk #(
    .N_BLK (N_BLK),
    .W_PM  (W_PM),
    .W_IDX (W_IDX)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .phase     (phase_q),
    .idx       (idx_q),
    .out_valid (out_valid),
    .pm_flat   (pm_flat)
);

// File: tb/sim_llr_viterbi_dec.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own decoded block.
module sim_llr_viterbi_dec;

    localparam int N = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [7:0] in_sys = '0;
    logic signed [7:0] in_par = '0;
    logic signed [7:0] in_apr = '0;
    logic out_valid;
    logic out_bit;

    int n_chk = 0;
    int n_err = 0;

    logic [N-1:0] ref_u;
    logic [N-1:0] par_b;
    logic [N-1:0] got;
    logic signed [7:0] vs [N];
    logic signed [7:0] vp [N];
    logic signed [7:0] va [N];

    always #5 clk = ~clk;

    llr_viterbi_dec #(.N_BLK(N)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sys    (in_sys),
        .in_par    (in_par),
        .in_apr    (in_apr),
        .out_valid (out_valid),
        .out_bit   (out_bit)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic signed [7:0] llr(input logic b, input int mag);
        return b ? 8'(mag) : 8'(-mag);
    endfunction

    // Information bits from a small linear congruential sequence.
    task automatic gen_bits(input int unsigned seed);
        int unsigned x;
        x = seed;
        for (int k = 0; k < N; k++) begin
            x = x * 32'd1103515245 + 32'd12345;
            ref_u[k] = x[16];
        end
    endtask

    // Reference encoder: w = u^d2^d3, v = w^d1^d3, then the delay line shifts (R2).
    task automatic encode();
        logic a1, a2, a3, w;
        a1 = 0; a2 = 0; a3 = 0;
        for (int k = 0; k < N; k++) begin
            w = ref_u[k] ^ a2 ^ a3;
            par_b[k] = w ^ a1 ^ a3;
            a3 = a2; a2 = a1; a1 = w;
        end
    endtask

    task automatic clean_llrs(input int mag);
        encode();
        for (int k = 0; k < N; k++) begin
            vs[k] = llr(ref_u[k], mag);
            vp[k] = llr(par_b[k], mag);
            va[k] = '0;
        end
    endtask

    task automatic drive_junk();
        in_valid = 1'b1;
        in_sys = 8'($urandom);
        in_par = 8'($urandom);
        in_apr = 8'($urandom);
    endtask

    task automatic idle_inputs();
        in_valid = 1'b0;
        in_sys = '0; in_par = '0; in_apr = '0;
    endtask

    // Feed one block, collect its output, and check bits, latency and run length (R6).
    task automatic run_block(input string req, input bit junk);
        int lat;
        bit contig;
        for (int k = 0; k < N; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sys = vs[k]; in_par = vp[k]; in_apr = va[k];
        end
        @(negedge clk);
        if (junk) drive_junk(); else idle_inputs();
        lat = 0;
        while (!out_valid && lat < 4 * N) begin
            @(negedge clk);
            lat++;
            if (junk) drive_junk();
        end
        check(lat == N + 1, "R6", "first output latency", 64'(lat), 64'(N + 1));
        contig = 1'b1;
        got = '0;
        for (int j = 0; j < N; j++) begin
            if (!out_valid) contig = 1'b0;
            got[j] = out_bit;
            if (junk && j < N - 1) drive_junk(); else idle_inputs();
            @(negedge clk);
        end
        check(contig, "R6", "valid run unbroken", 64'(contig), 64'd1);
        check(!out_valid, "R6", "valid run ends after N", 64'(out_valid), 64'd0);
        check(got == ref_u, req, "decoded block", 64'(got), 64'(ref_u));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        idle_inputs();
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            check(!out_valid, "R1", "out_valid during reset", 64'(out_valid), 64'd0);
        end
        rst_n = 1'b1;
        @(negedge clk);
        check(!out_valid, "R1", "out_valid after reset", 64'(out_valid), 64'd0);
    endtask

    task automatic t_clean();
        gen_bits(32'd7);   clean_llrs(60); run_block("R2", 1'b0);
        ref_u = '1;        clean_llrs(60); run_block("R2", 1'b0);
        for (int k = 0; k < N; k++) ref_u[k] = k[0];
        clean_llrs(45); run_block("R2", 1'b0);
    endtask

    task automatic t_full_scale();
        gen_bits(32'd99);
        encode();
        for (int k = 0; k < N; k++) begin
            vs[k] = ref_u[k] ? 8'sd127 : -8'sd128;
            vp[k] = par_b[k] ? 8'sd127 : -8'sd128;
            va[k] = ref_u[k] ? 8'sd127 : -8'sd128;
        end
        run_block("R3", 1'b0);
    endtask

    task automatic t_lower();
        gen_bits(32'd1234);
        encode();
        for (int k = 0; k < N; k++) begin
            vs[k] = '0;
            vp[k] = llr(par_b[k], 40);
            va[k] = llr(ref_u[k], 30);
        end
        run_block("R4", 1'b0);
    endtask

    task automatic t_override();
        gen_bits(32'd555);
        encode();
        for (int k = 0; k < N; k++) begin
            vs[k] = llr(!ref_u[k], 8);
            vp[k] = llr(par_b[k], 40);
            va[k] = llr(ref_u[k], 50);
        end
        run_block("R4", 1'b0);
    endtask

    task automatic t_sign();
        gen_bits(32'd31337);
        for (int k = 0; k < N; k++) begin
            vs[k] = llr(ref_u[k], 1 + (k % 50));
            vp[k] = '0;
            va[k] = '0;
        end
        run_block("R5", 1'b0);
    endtask

    task automatic t_zero();
        ref_u = '0;
        for (int k = 0; k < N; k++) begin
            vs[k] = '0; vp[k] = '0; va[k] = '0;
        end
        run_block("R8", 1'b0);
    endtask

    task automatic t_weak();
        gen_bits(32'd2024);
        clean_llrs(60);
        vp[20] = llr(!par_b[20], 5);
        run_block("R9", 1'b0);
    endtask

    task automatic t_busy();
        gen_bits(32'd77);  clean_llrs(50); run_block("R7", 1'b1);
        gen_bits(32'd78);  clean_llrs(50); run_block("R7", 1'b0);
    endtask

    task automatic t_reset_mid();
        gen_bits(32'd4242);
        clean_llrs(60);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_sys = 8'($urandom); in_par = 8'($urandom); in_apr = 8'($urandom);
        end
        t_reset();
        run_block("R1", 1'b0);
    endtask

    // Watchdog: a hung run counts as a failed check and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    // Scenario sequence.
    initial begin
        t_reset();
        t_clean();
        t_full_scale();
        t_lower();
        t_override();
        t_sign();
        t_zero();
        t_weak();
        t_busy();
        t_reset_mid();
        repeat (3) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule